// File: doc/BRIEF.md
# Console Printer Transfer-Instruction Controller

This block sits beside a processor's I/O bus and executes the transfer instructions aimed at the console printer. The processor presents the three function bits of an I/O instruction together with a valid strobe and the current accumulator. In the same cycle the block answers with a skip request and, for the print functions, a one-cycle character strobe that carries the low accumulator bits to a character sender.

The block owns the printer-ready flag. The sender raises a done pulse when a character has left, and that pulse sets the flag again. The keyboard side's ready flag is an input that only the combined skip function reads. The serial transmitter and the keyboard path are outside the block.

Top module: `console_print_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `ready_flag` is 0 and `char_stb` and `skip_req` are 0.
- R2: Function 0 (`op_fn` = 3'd0) with `op_vld` high sets `ready_flag` at the next clock edge.
- R3: Function 1 with `op_vld` high drives `skip_req` high in the same cycle exactly when `ready_flag` is 1.
- R4: Function 2 with `op_vld` high and no done pulse clears `ready_flag` at the next clock edge.
- R5: Function 4 with `op_vld` high pulses `char_stb` in the same cycle with `char_out` equal to `acc_in[7:0]`; `ready_flag` is left as it was; `char_out` is 0 whenever `char_stb` is low.
- R6: Function 5 with `op_vld` high drives `skip_req` high in the same cycle exactly when `ready_flag` or `kbd_flag` is 1.
- R7: Function 6 with `op_vld` high pulses `char_stb` with `char_out` equal to `acc_in[7:0]` and, with no done pulse, clears `ready_flag` at the next clock edge.
- R8: Functions 3 and 7 raise neither `char_stb` nor `skip_req` and leave `ready_flag` unchanged.
- R9: A `send_done` pulse sets `ready_flag` at the next clock edge, even when a clearing function arrives in the same cycle.
- R10: With `op_vld` low, `char_stb` and `skip_req` stay low whatever `op_fn` holds, and `ready_flag` changes only through `send_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | An I/O instruction for the printer is present this cycle |
| op_fn | input | 3 | Function bits of the instruction |
| acc_in | input | ACC_W | Accumulator contents |
| send_done | input | 1 | Character sender finished a character |
| kbd_flag | input | 1 | Keyboard ready flag from outside |
| char_stb | output | 1 | One-cycle strobe: send `char_out` |
| char_out | output | CHAR_W | Character taken from the low accumulator bits |
| skip_req | output | 1 | Request to skip the next instruction |
| ready_flag | output | 1 | Printer-ready flag |

## Verification
The two skip functions are tried with every combination of printer flag and keyboard flag, which separates the printer-only skip from the combined skip and catches a skip that looks at the wrong flag. The print functions are driven with accumulators whose upper bits differ from their low byte, so a wrong slice of the accumulator shows in the character, and they are issued with the flag both set and clear to tell the plain print from the print-and-clear. Clearing functions are sent in the same cycle as a done pulse to check that the pulse wins, and functions 3 and 7 as well as invalid cycles are sent with the flag in both states to show they touch nothing.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;
  typedef enum logic [2:0] {
    FN_FLAG_SET = 3'd0,
    FN_SKIP_RDY = 3'd1,
    FN_FLAG_CLR = 3'd2,
    FN_NOP_LO   = 3'd3,
    FN_SEND     = 3'd4,
    FN_SKIP_ANY = 3'd5,
    FN_SEND_CLR = 3'd6,
    FN_NOP_HI   = 3'd7
  } fn_e;

  typedef struct packed {
    logic set_f;
    logic clr_f;
    logic send;
    logic skip_rdy;
    logic skip_any;
  } act_t;

  // Action set for one instruction.
  function automatic act_t decode_fn(input logic vld, input logic [2:0] fn);
    act_t a;
    a = '0;
    if (vld) begin
      case (fn_e'(fn))
        FN_FLAG_SET: a.set_f    = 1'b1;
        FN_SKIP_RDY: a.skip_rdy = 1'b1;
        FN_FLAG_CLR: a.clr_f    = 1'b1;
        FN_SEND:     a.send     = 1'b1;
        FN_SKIP_ANY: a.skip_any = 1'b1;
        FN_SEND_CLR: begin
          a.send  = 1'b1;
          a.clr_f = 1'b1;
        end
        FN_NOP_LO, FN_NOP_HI: a = '0;
        default: a = '0;
      endcase
    end
    return a;
  endfunction

  // Done pulse has priority over a clear.
  function automatic logic flag_next(input logic cur, input logic done,
                                     input logic set_f, input logic clr_f);
    if (done || set_f) return 1'b1;
    if (clr_f)         return 1'b0;
    return cur;
  endfunction

  function automatic logic skip_eval(input logic sk_rdy, input logic sk_any,
                                     input logic rdy, input logic kbd);
    return (sk_rdy && rdy) || (sk_any && (rdy || kbd));
  endfunction
endpackage

// File: rtl/cpc_decode.sv
`timescale 1ns/1ps
module cpc_decode
  import cpc_pkg::*;
(
  input  logic       vld,
  input  logic [2:0] fn,
  output act_t       act
);
  always_comb act = decode_fn(vld, fn);
endmodule

// File: rtl/cpc_flag.sv
`timescale 1ns/1ps
module cpc_flag
  import cpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic set_f,
  input  logic clr_f,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, done, set_f, clr_f);
  end
endmodule

// File: rtl/cpc_xmit.sv
`timescale 1ns/1ps
module cpc_xmit #(
  parameter int ACC_W  = 12,
  parameter int CHAR_W = 8
) (
  input  logic              send,
  input  logic [ACC_W-1:0]  acc,
  output logic              stb,
  output logic [CHAR_W-1:0] data
);
  generate
    if (ACC_W > CHAR_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^acc[ACC_W-1:CHAR_W];
    end
  endgenerate

  assign stb  = send;
  assign data = send ? acc[CHAR_W-1:0] : '0;
endmodule

// File: rtl/console_print_ctrl.sv
`timescale 1ns/1ps
module console_print_ctrl
  import cpc_pkg::*;
#(
  parameter int ACC_W  = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_vld,
  input  logic [2:0]        op_fn,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              send_done,
  input  logic              kbd_flag,
  output logic              char_stb,
  output logic [CHAR_W-1:0] char_out,
  output logic              skip_req,
  output logic              ready_flag
);
  act_t act;
  logic set_req, clr_req, send_req;

  cpc_decode u_dec (.vld(op_vld), .fn(op_fn), .act(act));

  assign set_req  = act.set_f;
  assign clr_req  = act.clr_f;
  assign send_req = act.send;

  cpc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .done(send_done),
    .set_f(set_req), .clr_f(clr_req), .flag(ready_flag)
  );

  cpc_xmit #(.ACC_W(ACC_W), .CHAR_W(CHAR_W)) u_xmit (
    .send(send_req), .acc(acc_in), .stb(char_stb), .data(char_out)
  );

  assign skip_req = skip_eval(act.skip_rdy, act.skip_any, ready_flag, kbd_flag);
endmodule

// File: rtl/cpc_checker.sv
`timescale 1ns/1ps
module cpc_checker #(
  parameter int ACC_W  = 12,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_vld,
  input logic [2:0]        op_fn,
  input logic [ACC_W-1:0]  acc_in,
  input logic              send_done,
  input logic              kbd_flag,
  input logic              char_stb,
  input logic [CHAR_W-1:0] char_out,
  input logic              skip_req,
  input logic              ready_flag,
  input logic              clr_req
);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_fn == 3'd0 |=> ready_flag);
  assert_skip_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_fn == 3'd1 |-> skip_req == ready_flag);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !send_done |=> !ready_flag);
  assert_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    char_stb |-> op_vld && op_fn[2] && !op_fn[0] && char_out == acc_in[CHAR_W-1:0]);
  assert_skip_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_fn == 3'd5 |-> skip_req == (ready_flag || kbd_flag));
  assert_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_fn[1:0] == 2'b11 && !send_done |=> $stable(ready_flag));
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    send_done |=> ready_flag);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |-> !char_stb && !skip_req);
endmodule

bind console_print_ctrl cpc_checker #(.ACC_W(ACC_W), .CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/console_print_ctrl_test.sv
`timescale 1ns/1ps
module console_print_ctrl_test;
  localparam int ACC_W  = 12;
  localparam int CHAR_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic op_vld;
  logic [2:0] op_fn;
  logic [ACC_W-1:0] acc_in;
  logic send_done, kbd_flag;
  logic char_stb, skip_req, ready_flag;
  logic [CHAR_W-1:0] char_out;

  always #2 clk = ~clk;  // 250 MHz

  console_print_ctrl #(.ACC_W(ACC_W), .CHAR_W(CHAR_W)) uut (.*);

  typedef struct {
    logic stb;
    logic [CHAR_W-1:0] data;
    logic skip;
    logic flag;
    string req;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic mflag = 1'b0;
  bit done_run = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic v, logic [2:0] f, logic d);
    if (d) return "R9";
    if (!v) return "R10";
    case (f)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic v, input logic [2:0] f, input logic [ACC_W-1:0] a,
                      input logic d, input logic kb);
    exp_t e;
    @(negedge clk);
    op_vld = v; op_fn = f; acc_in = a; send_done = d; kbd_flag = kb;
    e.stb  = v && (f == 3'd4 || f == 3'd6);
    e.data = e.stb ? a[CHAR_W-1:0] : '0;
    e.skip = v && ((f == 3'd1 && mflag) || (f == 3'd5 && (mflag || kb)));
    if (d || (v && f == 3'd0))              mflag = 1'b1;
    else if (v && (f == 3'd2 || f == 3'd6)) mflag = 1'b0;
    e.flag = mflag;
    e.req  = tag_of(v, f, d);
    q.push_back(e);
  endtask

  // Monitor: compares same-cycle outputs, then the flag after the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "char_stb", char_stb, e.stb);
        check(e.req, "char_out", char_out, e.data);
        check(e.req, "skip_req", skip_req, e.skip);
        @(posedge clk);
        #1;
        check(e.req, "ready_flag", ready_flag, e.flag);
      end
    end
  end

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_vld = 1'b0; op_fn = 3'd0; acc_in = '0;
    send_done = 1'b0; kbd_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "ready_flag in reset", ready_flag, 0);
    check("R1", "char_stb in reset", char_stb, 0);
    check("R1", "skip_req in reset", skip_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd0, '0, 1'b0, 1'b0);          // R1 flag stays 0
    step(1'b1, 3'd1, '0, 1'b0, 1'b0);          // R3 flag clear: no skip
    step(1'b1, 3'd0, '0, 1'b0, 1'b0);          // R2 set
    step(1'b1, 3'd1, '0, 1'b0, 1'b0);          // R3 skip
    step(1'b1, 3'd2, '0, 1'b0, 1'b0);          // R4 clear
    step(1'b1, 3'd5, '0, 1'b0, 1'b0);          // R6 neither
    step(1'b1, 3'd5, '0, 1'b0, 1'b1);          // R6 keyboard only
    step(1'b1, 3'd1, '0, 1'b0, 1'b1);          // R3 ignores keyboard
    step(1'b1, 3'd4, 12'hABC, 1'b0, 1'b0);     // R5 low byte, flag 0 kept
    step(1'b1, 3'd0, '0, 1'b0, 1'b0);
    step(1'b1, 3'd4, 12'h3C5, 1'b0, 1'b0);     // R5 flag 1 kept
    step(1'b1, 3'd5, '0, 1'b0, 1'b0);          // R6 printer only
    step(1'b1, 3'd5, '0, 1'b0, 1'b1);          // R6 both
    step(1'b1, 3'd3, 12'hFFF, 1'b0, 1'b1);     // R8 flag 1
    step(1'b1, 3'd7, 12'hFFF, 1'b0, 1'b1);     // R8
    step(1'b1, 3'd6, 12'h955, 1'b0, 1'b0);     // R7 print and clear
    step(1'b1, 3'd3, 12'h0FF, 1'b0, 1'b1);     // R8 flag 0
    step(1'b1, 3'd7, 12'h0FF, 1'b0, 1'b1);     // R8
    step(1'b0, 3'd2, '0, 1'b1, 1'b0);          // R9 done sets
    step(1'b1, 3'd2, '0, 1'b1, 1'b0);          // R9 done beats clear
    step(1'b1, 3'd6, 12'h7AA, 1'b1, 1'b0);     // R9 done beats print-clear
    step(1'b0, 3'd4, 12'h123, 1'b0, 1'b1);     // R10 no strobe
    step(1'b0, 3'd1, '0, 1'b0, 1'b1);          // R10 no skip, flag 1
    step(1'b0, 3'd5, '0, 1'b0, 1'b1);          // R10
    step(1'b0, 3'd2, '0, 1'b0, 1'b0);          // R10 flag kept
    step(1'b0, 3'd6, 12'h456, 1'b0, 1'b0);     // R10 flag kept
    for (int i = 0; i < 32; i++)
      step(1'b1, 3'(i % 8), 12'(i * 173), (i % 5) == 0, (i % 3) == 0);
    repeat (3) @(negedge clk);
    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule